// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register side of a general-purpose I/O controller for up to 192 pins. The pins are grouped into banks of 32, and each register function holds one 32-bit word per bank. A simple register bus carries the address, a write strobe, write data and combinational read data. The block turns accesses on that bus into per-pin state. That state covers direction, output level, edge enables, interrupt mask, input type, level polarity and glitch bypass.

The direction and output-level bits drive the pads. Pad inputs are synchronised and then captured into a read-only level word. A separate per-pin event detector reads the edge, type, polarity and bypass settings from this block. It returns one-cycle hit pulses, which this block latches into an interrupt status word. The block also produces a single combined interrupt line.

Output levels change only through two write-only words. One of them sets pins and the other clears them, so software never needs a read-modify-write to change a pin.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every read/write word reads zero, `pad_oe`, `pad_out` and all detector settings are zero, and `irq` is low.
- R2: The function base addresses are: pad level 0x004, direction 0x01C, set 0x034, clear 0x04C, rising enable 0x064, falling enable 0x07C, glitch bypass 0x094, mask 0x0AC, status 0x0C4, input type 0x300, polarity 0x318. Pin n of a function lives at base + 4*(n/32), bit n%32. The control word sits alone at 0x000.
- R3: Writing the set word raises `pad_out` for every pin whose data bit is 1, and pins whose bit is 0 keep their level. Reading a set or clear address returns zero.
- R4: Writing the clear word lowers `pad_out` for every pin whose data bit is 1, and pins whose bit is 0 keep their level.
- R5: A direction bit of 1 asserts that pin's `pad_oe` (output), and 0 releases it (input). The direction word reads back as written.
- R6: The pad level word is read-only, and writes to it have no effect. A pad change becomes visible there on the third rising clock edge after it: two synchroniser stages, then the level capture.
- R7: An `ev_hit` pulse sets that pin's status bit. Writing 1 to a status bit clears it, and writing 0 leaves it. A hit in the same cycle as a clearing write leaves the bit set.
- R8: `irq` is high exactly when some pin has both its status bit and its mask bit at 1, with mask 1 meaning enabled. The status bit latches regardless of the mask.
- R9: The rising, falling, bypass, input-type and polarity words read back as written and appear bit for bit on `ev_rise_en`, `ev_fall_en`, `ev_bypass`, `ev_level_mode` and `ev_low_active`. Writing zero to both edge words clears every edge enable. The control word at 0x000 reads back and drives `cfg_word`.
- R10: An access to an address that is unmapped, lies in a bank beyond `BANKS`, or is not word-aligned changes no state, and a read from it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32*BANKS | Raw pad input levels |
| pad_oe | output | 32*BANKS | Output enable per pin |
| pad_out | output | 32*BANKS | Output level per pin |
| ev_hit | input | 32*BANKS | One-cycle event pulses from the detector |
| ev_rise_en | output | 32*BANKS | Rising-edge enable per pin |
| ev_fall_en | output | 32*BANKS | Falling-edge enable per pin |
| ev_bypass | output | 32*BANKS | Glitch-filter bypass per pin |
| ev_level_mode | output | 32*BANKS | Input type per pin (1 = level) |
| ev_low_active | output | 32*BANKS | Level polarity per pin (1 = active low) |
| cfg_word | output | 32 | Control word |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong bank decode writes the neighbouring 32 pins, and this shows on `pad_oe`, `pad_out` or a detector setting one edge after the write. A bad status update shows on `irq` in the cycle after the hit or the clearing write. A lost set-over-clear priority leaves a status bit at zero where a one belongs. A synchroniser with the wrong depth moves the level read by a cycle, and the bench samples exactly at the second and third edges to catch that.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W    = 12;
    localparam int WORD_W    = 32;
    localparam int MAX_BANKS = 6;

    typedef enum logic [3:0] {
        K_NONE, K_CTRL, K_LVL, K_DIR, K_SET, K_CLR, K_RISE,
        K_FALL, K_BYP, K_MASK, K_STAT, K_ITYPE, K_POL
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] bank;
    } dec_t;

    typedef struct packed {
        logic dir;
        logic set;
        logic clr;
        logic rise;
        logic fall;
        logic byp;
        logic mask;
        logic stat;
        logic itype;
        logic pol;
    } bank_we_t;

    typedef struct packed {
        logic [WORD_W-1:0] lvl;
        logic [WORD_W-1:0] dir;
        logic [WORD_W-1:0] outv;
        logic [WORD_W-1:0] rise;
        logic [WORD_W-1:0] fall;
        logic [WORD_W-1:0] byp;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] stat;
        logic [WORD_W-1:0] itype;
        logic [WORD_W-1:0] pol;
    } bank_regs_t;

    function automatic logic [ADDR_W-1:0] kind_base(input kind_e k);
        case (k)
            K_LVL:   return 12'h004;
            K_DIR:   return 12'h01C;
            K_SET:   return 12'h034;
            K_CLR:   return 12'h04C;
            K_RISE:  return 12'h064;
            K_FALL:  return 12'h07C;
            K_BYP:   return 12'h094;
            K_MASK:  return 12'h0AC;
            K_STAT:  return 12'h0C4;
            K_ITYPE: return 12'h300;
            K_POL:   return 12'h318;
            default: return 12'hFFF;
        endcase
    endfunction

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int nb);
        dec_t d;
        d.kind = K_NONE;
        d.bank = '0;
        if (a == '0) d.kind = K_CTRL;
        for (int k = int'(K_LVL); k <= int'(K_POL); k++) begin
            for (int b = 0; b < MAX_BANKS; b++) begin
                if (b < nb && a == kind_base(kind_e'(k)) + ADDR_W'(4 * b)) begin
                    d.kind = kind_e'(k);
                    d.bank = 8'(b);
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) st[i] <= '0;
                else if (i == 0) st[i] <= d;
                else st[i] <= st[(i == 0) ? 0 : i - 1];
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bank_we_t          we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] pad_sync,
    input  logic [WORD_W-1:0] evt,
    output bank_regs_t        regs
);
    logic [WORD_W-1:0] stat_clr;

    assign stat_clr = we.stat ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            regs.lvl <= pad_sync;
            if (we.dir)   regs.dir   <= wdata;
            if (we.rise)  regs.rise  <= wdata;
            if (we.fall)  regs.fall  <= wdata;
            if (we.byp)   regs.byp   <= wdata;
            if (we.mask)  regs.mask  <= wdata;
            if (we.itype) regs.itype <= wdata;
            if (we.pol)   regs.pol   <= wdata;
            if (we.set)   regs.outv  <= regs.outv | wdata;
            else if (we.clr) regs.outv <= regs.outv & ~wdata;
            regs.stat <= (regs.stat & ~stat_clr) | evt;
        end
    end

    // R3
    set_drive_chk: assert property (@(posedge clk) disable iff (rst)
        we.set |=> ((regs.outv & $past(wdata)) == $past(wdata)));

    // R4
    clr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        we.clr |=> ((regs.outv & $past(wdata)) == '0));

    // R7
    evt_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((regs.stat & $past(evt)) == $past(evt)));

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we.stat && evt == '0) |=> ((regs.stat & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int BANKS       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    input  logic [WORD_W*BANKS-1:0]  pad_in,
    output logic [WORD_W*BANKS-1:0]  pad_oe,
    output logic [WORD_W*BANKS-1:0]  pad_out,
    input  logic [WORD_W*BANKS-1:0]  ev_hit,
    output logic [WORD_W*BANKS-1:0]  ev_rise_en,
    output logic [WORD_W*BANKS-1:0]  ev_fall_en,
    output logic [WORD_W*BANKS-1:0]  ev_bypass,
    output logic [WORD_W*BANKS-1:0]  ev_level_mode,
    output logic [WORD_W*BANKS-1:0]  ev_low_active,
    output logic [WORD_W-1:0]        cfg_word,
    output logic                     irq
);
    localparam int PINS = WORD_W * BANKS;

    dec_t              dec;
    bank_regs_t        regs [BANKS];
    logic [PINS-1:0]   pad_sync;
    logic [BANKS-1:0]  bank_irq;
    logic [WORD_W-1:0] ctrl_q;

    assign dec = decode_addr(bus_addr, BANKS);

    gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (bus_we && dec.kind == K_CTRL) ctrl_q <= bus_wdata;
    end
    assign cfg_word = ctrl_q;

    genvar b;
    generate
        for (b = 0; b < BANKS; b++) begin : g_bank
            bank_we_t we_b;
            logic     sel;

            assign sel = bus_we && (dec.bank == 8'(b));

            always_comb begin
                we_b       = '0;
                we_b.dir   = sel && dec.kind == K_DIR;
                we_b.set   = sel && dec.kind == K_SET;
                we_b.clr   = sel && dec.kind == K_CLR;
                we_b.rise  = sel && dec.kind == K_RISE;
                we_b.fall  = sel && dec.kind == K_FALL;
                we_b.byp   = sel && dec.kind == K_BYP;
                we_b.mask  = sel && dec.kind == K_MASK;
                we_b.stat  = sel && dec.kind == K_STAT;
                we_b.itype = sel && dec.kind == K_ITYPE;
                we_b.pol   = sel && dec.kind == K_POL;
            end

            gpio_bank u_bank (
                .clk      (clk),
                .rst      (rst),
                .we       (we_b),
                .wdata    (bus_wdata),
                .pad_sync (pad_sync[b*WORD_W +: WORD_W]),
                .evt      (ev_hit[b*WORD_W +: WORD_W]),
                .regs     (regs[b])
            );

            assign pad_oe[b*WORD_W +: WORD_W]        = regs[b].dir;
            assign pad_out[b*WORD_W +: WORD_W]       = regs[b].outv;
            assign ev_rise_en[b*WORD_W +: WORD_W]    = regs[b].rise;
            assign ev_fall_en[b*WORD_W +: WORD_W]    = regs[b].fall;
            assign ev_bypass[b*WORD_W +: WORD_W]     = regs[b].byp;
            assign ev_level_mode[b*WORD_W +: WORD_W] = regs[b].itype;
            assign ev_low_active[b*WORD_W +: WORD_W] = regs[b].pol;
            assign bank_irq[b] = |(regs[b].stat & regs[b].mask);
        end
    endgenerate

    assign irq = |bank_irq;

    always_comb begin
        bank_regs_t s;
        s = '0;
        for (int i = 0; i < BANKS; i++) begin
            if (dec.bank == 8'(i)) s = regs[i];
        end
        case (dec.kind)
            K_CTRL:  bus_rdata = ctrl_q;
            K_LVL:   bus_rdata = s.lvl;
            K_DIR:   bus_rdata = s.dir;
            K_RISE:  bus_rdata = s.rise;
            K_FALL:  bus_rdata = s.fall;
            K_BYP:   bus_rdata = s.byp;
            K_MASK:  bus_rdata = s.mask;
            K_STAT:  bus_rdata = s.stat;
            K_ITYPE: bus_rdata = s.itype;
            K_POL:   bus_rdata = s.pol;
            default: bus_rdata = '0;
        endcase
    end

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !bus_we) |=> irq);

    // R5
    dir_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && dec.kind == K_DIR && dec.bank == 8'd0) |=>
        (pad_oe[WORD_W-1:0] == $past(bus_wdata)));
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
    localparam int BANKS = 2;
    localparam int PINS  = 32 * BANKS;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [11:0]     bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [PINS-1:0] pad_in = '0;
    logic [PINS-1:0] pad_oe, pad_out, ev_rise_en, ev_fall_en, ev_bypass;
    logic [PINS-1:0] ev_level_mode, ev_low_active;
    logic [PINS-1:0] ev_hit = '0;
    logic [31:0]     cfg_word;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_bank_ctrl #(.BANKS(BANKS), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .ev_hit(ev_hit),
        .ev_rise_en(ev_rise_en), .ev_fall_en(ev_fall_en), .ev_bypass(ev_bypass),
        .ev_level_mode(ev_level_mode), .ev_low_active(ev_low_active),
        .cfg_word(cfg_word), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, 64'(v), 64'(exp));
    endtask

    task automatic t_reset;
        rd_chk("R1 dir0", 12'h01C, 0);
        rd_chk("R1 mask1", 12'h0B0, 0);
        rd_chk("R1 pol1", 12'h31C, 0);
        rd_chk("R1 ctrl", 12'h000, 0);
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 pad_out", pad_out, 0);
        chk("R1 irq", 64'(irq), 0);
    endtask

    task automatic t_set_clear;
        wr(12'h038, 32'h0000_8001);
        chk("R3 R2 set bank1", pad_out, 64'h0000_8001_0000_0000);
        rd_chk("R3 set reads zero", 12'h038, 0);
        wr(12'h034, 32'h0000_0010);
        chk("R3 set bank0 zeros keep", pad_out, 64'h0000_8001_0000_0010);
        wr(12'h050, 32'h0000_0001);
        chk("R4 clear bank1", pad_out, 64'h0000_8000_0000_0010);
        rd_chk("R3 clear reads zero", 12'h050, 0);
        wr(12'h04C, 32'h0);
        chk("R4 clear zeros keep", pad_out, 64'h0000_8000_0000_0010);
    endtask

    task automatic t_dir;
        wr(12'h020, 32'h0000_00F0);
        chk("R5 R2 dir bank1", pad_oe, 64'h0000_00F0_0000_0000);
        rd_chk("R5 dir readback", 12'h020, 32'h0000_00F0);
        wr(12'h01C, 32'h8000_0000);
        chk("R5 dir bank0", pad_oe, 64'h0000_00F0_8000_0000);
    endtask

    task automatic t_level;
        pad_in = 64'hDEAD_0000_0000_BEEF;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd_chk("R6 level not yet after two edges", 12'h004, 0);
        @(posedge clk); @(negedge clk);
        rd_chk("R6 level bank0 third edge", 12'h004, 32'h0000_BEEF);
        rd_chk("R6 R2 level bank1", 12'h008, 32'hDEAD_0000);
        wr(12'h004, 32'hFFFF_FFFF);
        rd_chk("R6 level write ignored", 12'h004, 32'h0000_BEEF);
    endtask

    task automatic t_status;
        ev_hit = '0;
        ev_hit[3] = 1'b1; ev_hit[40] = 1'b1;
        @(posedge clk); @(negedge clk);
        ev_hit = '0;
        rd_chk("R7 status bank0", 12'h0C4, 32'h8);
        rd_chk("R7 status bank1", 12'h0C8, 32'h100);
        chk("R8 irq masked", 64'(irq), 0);
        wr(12'h0B0, 32'h100);
        chk("R8 irq enabled", 64'(irq), 1);
        wr(12'h0C8, 32'h0);
        rd_chk("R7 write zero keeps", 12'h0C8, 32'h100);
        wr(12'h0C8, 32'h100);
        chk("R8 irq after clear", 64'(irq), 0);
        rd_chk("R7 other bank kept", 12'h0C4, 32'h8);
        wr(12'h0C4, 32'h8);
        rd_chk("R7 cleared", 12'h0C4, 32'h0);
        ev_hit[3] = 1'b1;
        wr(12'h0C4, 32'h8);
        ev_hit = '0;
        rd_chk("R7 hit beats clear", 12'h0C4, 32'h8);
        wr(12'h0AC, 32'h8);
        chk("R8 irq bank0", 64'(irq), 1);
        wr(12'h0AC, 32'h0);
        chk("R8 irq mask off", 64'(irq), 0);
    endtask

    task automatic t_cfg;
        wr(12'h068, 32'h0000_0003);
        wr(12'h07C, 32'h0000_0005);
        wr(12'h094, 32'h1234_5678);
        wr(12'h304, 32'h8000_0000);
        wr(12'h318, 32'h0000_00AA);
        wr(12'h000, 32'hA5A5_0001);
        chk("R9 rise", ev_rise_en, 64'h0000_0003_0000_0000);
        chk("R9 fall", ev_fall_en, 64'h0000_0000_0000_0005);
        chk("R9 bypass", ev_bypass, 64'h0000_0000_1234_5678);
        chk("R9 itype", ev_level_mode, 64'h8000_0000_0000_0000);
        chk("R9 pol", ev_low_active, 64'h0000_0000_0000_00AA);
        chk("R9 cfg", 64'(cfg_word), 64'hA5A5_0001);
        rd_chk("R9 rise readback", 12'h068, 32'h3);
        rd_chk("R9 ctrl readback", 12'h000, 32'hA5A5_0001);
        wr(12'h064, 32'h0); wr(12'h068, 32'h0);
        wr(12'h07C, 32'h0); wr(12'h080, 32'h0);
        chk("R9 edges off", ev_rise_en | ev_fall_en, 0);
    endtask

    task automatic t_unmapped;
        logic [63:0] oe0, out0;
        oe0 = pad_oe; out0 = pad_out;
        wr(12'h024, 32'hFFFF_FFFF);
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h01E, 32'hFFFF_FFFF);
        wr(12'h03C, 32'hFFFF_FFFF);
        wr(12'h320, 32'hFFFF_FFFF);
        chk("R10 pad_oe unchanged", pad_oe, oe0);
        chk("R10 pad_out unchanged", pad_out, out0);
        chk("R10 pol unchanged", ev_low_active, 64'h0000_0000_0000_00AA);
        chk("R10 cfg unchanged", 64'(cfg_word), 64'hA5A5_0001);
        rd_chk("R10 read beyond bank", 12'h024, 0);
        rd_chk("R10 read unaligned", 12'h01E, 0);
        rd_chk("R10 read gap", 12'h200, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_set_clear;
        t_dir;
        t_level;
        t_status;
        t_cfg;
        t_unmapped;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule